// File: doc/BRIEF.md
# Ping-Pong Frame Capture Controller

This block moves a stream of samples into two alternating frame buffers with no processor involvement. One buffer is being filled from a valid/ready sample stream while the processor owns the other. When the fill side has written a full frame, the two buffers trade places and an interrupt tells the processor that a fresh frame is waiting.

The interrupt is a level. It stays high until the processor pulses its acknowledge input. If another frame completes while the interrupt is still pending, the processor has fallen behind. A sticky overrun flag records this.

The write port drives both buffer memories. They share one address and one data bus, and each buffer has its own write enable. The sample stream is accepted whenever it is valid, because the controller never stalls once it is out of reset.

Top module: `pingpong_capture`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `irq`, `overrun` and both `wr_en` bits are 0, and `cpu_buf` is 1, so the processor owns buffer 1 and buffer 0 is filled first.
- R2: `in_ready` goes high at the first rising clock edge at which `rst_n` is high. It then stays high until the next reset.
- R3: A sample is accepted when `in_valid` and `in_ready` are both high. In that same cycle exactly one write enable is high: bit b of `wr_en` writes buffer b, and it is the buffer the processor does not own. `wr_data` equals `in_data`. With no accepted sample, `wr_en` is 0.
- R4: `wr_addr` starts at 0 after reset and advances by one only on an accepted sample. After address FRAME_LEN-1 it wraps to 0. Cycles with no accepted sample leave it unchanged.
- R5: The accepted sample at address FRAME_LEN-1 completes a frame. From the next cycle, `cpu_buf` names the buffer that was just filled, and the other buffer is filled next. `cpu_buf` changes at no other time.
- R6: `irq` rises in the cycle after a frame completes. It stays high until a cycle with `cpu_ack` high and no frame completion, and it falls in the cycle after that acknowledge.
- R7: When `cpu_ack` is high in the same cycle a frame completes, the completion wins. `irq` stays high and no overrun is recorded.
- R8: A frame that completes while `irq` is high and `cpu_ack` is low sets `overrun` in the next cycle. `overrun` then stays high until reset, whatever `cpu_ack` does.
- R9: The buffer named by `cpu_buf` is never written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample present on `in_data` |
| in_data | input | DATA_W | Sample value |
| in_ready | output | 1 | Controller can take a sample |
| wr_en | output | 2 | Per-buffer write enable, bit b for buffer b |
| wr_addr | output | ADDR_W | Write address within the buffer being filled |
| wr_data | output | DATA_W | Data written to the buffer |
| cpu_buf | output | 1 | Index of the buffer the processor owns |
| irq | output | 1 | Frame-ready interrupt, level |
| cpu_ack | input | 1 | Processor acknowledge of the interrupt |
| overrun | output | 1 | Sticky flag: a frame completed before the last one was acknowledged |

## Verification
The bench builds the block with FRAME_LEN = 8 and DATA_W = 12. The short frame brings five buffer swaps within a few dozen cycles, along with the address wrap, gapped and continuous streams, an acknowledge that lands on the completing sample, and a second frame that completes with no acknowledge. A 12-bit sample width checks that `wr_data` does not depend on any particular power-of-two data width.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // Next write address inside a frame of len samples.
  function automatic int unsigned next_slot(input int unsigned slot, input int unsigned len);
    return (slot == len - 1) ? 0 : slot + 1;
  endfunction

  // True when slot is the final sample position of a frame.
  function automatic logic is_final_slot(input int unsigned slot, input int unsigned len);
    return slot == len - 1;
  endfunction
endpackage

// File: rtl/pp_addr_ctr.sv
module pp_addr_ctr #(
  parameter int FRAME_LEN = 64,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  output logic [ADDR_W-1:0] slot,
  output logic              frame_done
);
  import pp_pkg::*;

  logic [ADDR_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      slot_q <= '0;
    else if (accept)
      slot_q <= ADDR_W'(next_slot(int'(unsigned'(slot_q)), FRAME_LEN));
  end

  assign slot       = slot_q;
  assign frame_done = accept && is_final_slot(int'(unsigned'(slot_q)), FRAME_LEN);
endmodule

// File: rtl/pp_owner.sv
module pp_owner (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  output logic fill_sel
);
  logic fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      fill_q <= 1'b0;
    else if (frame_done)
      fill_q <= ~fill_q;
  end

  assign fill_sel = fill_q;
endmodule

// File: rtl/pp_irq.sv
module pp_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic cpu_ack,
  output logic irq,
  output logic overrun
);
  logic irq_q;
  logic ovr_q;
  logic behind;

  // A completion that finds an unacknowledged interrupt means the CPU is late.
  assign behind = frame_done && irq_q && !cpu_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (frame_done)
        irq_q <= 1'b1;
      else if (cpu_ack)
        irq_q <= 1'b0;
      if (behind)
        ovr_q <= 1'b1;
    end
  end

  assign irq     = irq_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture #(
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 64,
  parameter int ADDR_W    = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [1:0]        wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              cpu_buf,
  output logic              irq,
  input  logic              cpu_ack,
  output logic              overrun
);
  localparam int NBUF = 2;

  logic ready_q;
  logic accept;
  logic frame_done;
  logic fill_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  pp_addr_ctr #(.FRAME_LEN(FRAME_LEN), .ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .slot(wr_addr), .frame_done(frame_done)
  );

  pp_owner u_owner (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .fill_sel(fill_sel)
  );

  pp_irq u_irq (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .cpu_ack(cpu_ack),
    .irq(irq), .overrun(overrun)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_we
    assign wr_en[b] = accept && (fill_sel == 1'(b));
  end

  assign wr_data = in_data;
  assign cpu_buf = ~fill_sel;
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [1:0]        wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cpu_buf,
  input logic              irq,
  input logic              cpu_ack,
  input logic              overrun,
  input logic              accept,
  input logic              frame_done
);
  a_r2_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
  a_r3_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en) && ((wr_en != 2'b00) == accept));
  a_r4_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(wr_addr));
  a_r5_swap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> cpu_buf != $past(cpu_buf));
  a_r5_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(cpu_buf));
  a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> irq);
  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cpu_ack) |=> irq);
  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && irq && !cpu_ack) |=> overrun);
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  a_r9_cpu_buf_safe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[cpu_buf] == 1'b0);
endmodule

bind pingpong_capture pp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .wr_en(wr_en),
  .wr_addr(wr_addr), .cpu_buf(cpu_buf), .irq(irq), .cpu_ack(cpu_ack),
  .overrun(overrun), .accept(accept), .frame_done(frame_done)
);

// File: tb/pingpong_capture_bench.sv
`timescale 1ns/1ps
module pingpong_capture_bench;
  localparam int DW  = 12;
  localparam int LEN = 8;
  localparam int AW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic cpu_ack = 1'b0;
  logic in_ready;
  logic [1:0] wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic cpu_buf, irq, overrun;

  always #2 clk = ~clk;

  pingpong_capture #(.DATA_W(DW), .FRAME_LEN(LEN)) u_pingpong_capture (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_buf(cpu_buf), .irq(irq), .cpu_ack(cpu_ack), .overrun(overrun)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int sample_no = 0;

  // Reference model state
  int m_slot = 0;
  int m_fill = 0;
  int m_irq  = 0;
  int m_ovr  = 0;
  int m_rdy  = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // One clock: drive inputs, compare against the model, then advance the model.
  task automatic step(input bit rst, input bit v, input bit ack);
    int take, done;
    rst_n    = rst;
    in_valid = v;
    in_data  = DW'(sample_no * 37 + 5);
    cpu_ack  = ack;
    #1;
    take = (m_rdy != 0 && v) ? 1 : 0;
    chk(rst ? "R2 in_ready" : "R1 in_ready", int'(in_ready), m_rdy);
    chk(rst ? "R3 wr_en" : "R1 wr_en", int'(wr_en), take ? (1 << m_fill) : 0);
    chk("R4 wr_addr", int'(wr_addr), m_slot);
    if (take != 0) chk("R3 wr_data", int'(wr_data), int'(in_data));
    chk(rst ? "R5 cpu_buf" : "R1 cpu_buf", int'(cpu_buf), 1 - m_fill);
    chk(rst ? "R6 irq" : "R1 irq", int'(irq), m_irq);
    chk(rst ? "R8 overrun" : "R1 overrun", int'(overrun), m_ovr);
    chk("R9 cpu buffer untouched", int'(wr_en[cpu_buf]), 0);
    @(posedge clk);
    if (!rst) begin
      m_slot = 0; m_fill = 0; m_irq = 0; m_ovr = 0; m_rdy = 0;
    end else begin
      done = (take != 0 && m_slot == LEN - 1) ? 1 : 0;
      if (take != 0) begin
        m_slot = (m_slot + 1) % LEN;
        sample_no++;
      end
      if (done != 0 && m_irq != 0 && !ack) m_ovr = 1;
      if (done != 0) begin
        m_irq = 1;
        m_fill = 1 - m_fill;
      end else if (ack) m_irq = 0;
      m_rdy = 1;
    end
    @(negedge clk);
  endtask

  // Push a full frame; gap inserts an idle cycle after every accepted sample.
  task automatic frame(input bit gap, input bit ack_on_last);
    int got = 0;
    while (got < LEN) begin
      bit last = (got == LEN - 1);
      step(1'b1, 1'b1, ack_on_last && last);
      got++;
      if (gap && got < LEN) step(1'b1, 1'b0, 1'b0);
    end
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset with valid asserted must not write or assert ready
    repeat (3) step(1'b0, 1'b1, 1'b0);
    // R2: first cycle after release, ready not yet high
    step(1'b1, 1'b1, 1'b0);
    // Frame 1: continuous stream (R3, R4, R5, R6)
    frame(1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    // Frame 2: gapped stream, address holds in gaps (R4)
    frame(1'b1, 1'b0);
    // Frame 3: acknowledge lands on completing sample (R7)
    frame(1'b0, 1'b1);
    chk("R7 irq kept on coincident ack", int'(irq), 1);
    chk("R7 no overrun on coincident ack", int'(overrun), 0);
    step(1'b1, 1'b0, 1'b1);
    chk("R6 irq cleared by ack", int'(irq), 0);
    // Frames 4 and 5 with no acknowledge: overrun (R8)
    frame(1'b0, 1'b0);
    frame(1'b1, 1'b0);
    chk("R8 overrun set", int'(overrun), 1);
    step(1'b1, 1'b0, 1'b1);
    repeat (3) step(1'b1, 1'b0, 1'b0);
    chk("R8 overrun sticky after ack", int'(overrun), 1);
    // Reset again clears everything (R1)
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk("R1 overrun cleared by reset", int'(overrun), 0);
    step(1'b1, 1'b1, 1'b0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule